// File: doc/BRIEF.md
# Centroid Defuzzifier

This block turns the outputs of up to four fired fuzzy rules into one crisp number by the weighted-average (center-of-gravity) method. Each rule supplies an 8-bit firing strength and a 2-bit consequent position (0 to 3). The block forms the sum of strength-times-position products as the numerator and the sum of strengths as the denominator. It then divides the numerator, scaled up by eight fraction bits, by the denominator in a restoring shift-subtract divider. The divider yields one quotient bit per clock. The crisp result is an unsigned fixed-point value with two integer and eight fraction bits. A PID stage can use it as a gain adjustment.

A caller pulses `start` with the rule data on the inputs. The block captures the inputs, computes, and raises `valid` for one cycle when `result` holds the new value. A state machine sequences the work through four states:
- **IDLE**: waits for `start`. `start` moves it to LOAD and captures the inputs.
- **LOAD**: forms the sums. A zero denominator goes directly to FINISH with a result of 0. Otherwise it launches the divider and goes to DIV.
- **DIV**: waits for the divider's done pulse, stores the quotient, and goes to FINISH.
- **FINISH**: raises `valid` for one cycle and returns to IDLE.

Top module: `centroid_defuzz`

## Requirements
- R1: After reset, `valid` and `busy` are 0 and `result` is 0.
- R2: Rule k's strength is taken from `strength_i[8k+7:8k]` and its position from `position_i[2k+1:2k]`. For a nonzero strength sum, `result` equals floor(256 × Σ strength×position / Σ strength).
- R3: For a nonzero strength sum, `valid` is high for exactly one cycle, 22 clock edges after the edge that accepts `start`.
- R4: If all four strengths are zero, no division runs. `valid` rises one edge after `start` is accepted, with `result` equal to 0.
- R5: A `start` that arrives while `busy` is high has no effect. Input changes after an accepted `start` do not affect that result.
- R6: `busy` is high from the edge that accepts `start` through the cycle in which `valid` is high, and low otherwise.
- R7: `result` changes only in a cycle where `valid` is high, and holds its value between `valid` pulses.
- R8: Full-scale inputs give exact values. All strengths 255 at position 3 give 768. A single nonzero rule at position p gives p×256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; accepted only when idle |
| strength_i | input | 32 | Four 8-bit rule firing strengths |
| position_i | input | 8 | Four 2-bit consequent positions |
| busy | output | 1 | Computation in progress |
| valid | output | 1 | One-cycle pulse: new result present |
| result | output | 10 | Crisp output, 2 integer + 8 fraction bits |

## Verification
Several input patterns are used, and each separates a different fault:
- An all-zero strength set separates the short zero path from the divider path.
- Single-rule inputs give exact multiples of 256, which exposes a wrong position weight or a swapped rule lane.
- All-full inputs reach the widest numerator and denominator, so they expose a truncated sum.
- Mixed and pseudo-random sets with non-integer averages expose quotient bit errors and rounding.
- A second `start` sent mid-computation, together with inputs changed after acceptance, shows whether a busy request or late data leaks into the result.

// File: rtl/defuzz_pkg.sv
package defuzz_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DIV,
        ST_FINISH
    } dfz_state_e;
endpackage

// File: rtl/cog_sum.sv
// Weighted and plain sums of the rule strengths.
module cog_sum #(
    parameter int N_RULES = 4,
    parameter int STR_W   = 8,
    parameter int POS_W   = 2,
    parameter int NUM_W   = STR_W + POS_W + $clog2(N_RULES),
    parameter int DEN_W   = STR_W + $clog2(N_RULES)
) (
    input  logic [N_RULES*STR_W-1:0] str_flat,
    input  logic [N_RULES*POS_W-1:0] pos_flat,
    output logic [NUM_W-1:0]         num,
    output logic [DEN_W-1:0]         den
);
    localparam int PROD_W = STR_W + POS_W;

    logic [PROD_W-1:0] prod [N_RULES];
    logic [STR_W-1:0]  str  [N_RULES];

    for (genvar k = 0; k < N_RULES; k++) begin : g_lane
        assign str[k]  = str_flat[k*STR_W +: STR_W];
        assign prod[k] = PROD_W'(str[k]) * PROD_W'(pos_flat[k*POS_W +: POS_W]);
    end

    always_comb begin
        num = '0;
        den = '0;
        for (int k = 0; k < N_RULES; k++) begin
            num = num + NUM_W'(prod[k]);
            den = den + DEN_W'(str[k]);
        end
    end
endmodule

// File: rtl/cog_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module cog_divider #(
    parameter int DIVD_W = 20,
    parameter int DEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DIVD_W-1:0] dividend,
    input  logic [DEN_W-1:0]  divisor,
    output logic              done,
    output logic [DIVD_W-1:0] quot
);
    localparam int CNT_W = $clog2(DIVD_W + 1);

    logic [DIVD_W-1:0] dvd_q, quot_q;
    logic [DEN_W-1:0]  rem_q, den_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q, done_q;
    logic [DEN_W:0]    rem_sh, diff;
    logic              ge;

    always_comb begin
        rem_sh = {rem_q, dvd_q[DIVD_W-1]};
        ge     = rem_sh >= {1'b0, den_q};
        diff   = rem_sh - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            quot_q <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (go) begin
            dvd_q  <= dividend;
            den_q  <= divisor;
            rem_q  <= '0;
            quot_q <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (run_q) begin
                dvd_q  <= dvd_q << 1;
                rem_q  <= ge ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                quot_q <= {quot_q[DIVD_W-2:0], ge};
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(DIVD_W - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = quot_q;
endmodule

// File: rtl/centroid_defuzz.sv
module centroid_defuzz #(
    parameter int N_RULES = 4,
    parameter int STR_W   = 8,
    parameter int POS_W   = 2,
    parameter int FRAC_W  = 8,
    localparam int OUT_W  = POS_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [N_RULES*STR_W-1:0] strength_i,
    input  logic [N_RULES*POS_W-1:0] position_i,
    output logic                     busy,
    output logic                     valid,
    output logic [OUT_W-1:0]         result
);
    import defuzz_pkg::*;

    localparam int NUM_W  = STR_W + POS_W + $clog2(N_RULES);
    localparam int DEN_W  = STR_W + $clog2(N_RULES);
    localparam int DIVD_W = NUM_W + FRAC_W;

    dfz_state_e state_q, state_d;

    logic [N_RULES*STR_W-1:0] str_q;
    logic [N_RULES*POS_W-1:0] pos_q;
    logic [NUM_W-1:0]         num;
    logic [DEN_W-1:0]         den;
    logic                     den_zero, div_go, div_done;
    logic [DIVD_W-1:0]        quot;
    logic [OUT_W-1:0]         result_q;

    cog_sum #(
        .N_RULES(N_RULES), .STR_W(STR_W), .POS_W(POS_W),
        .NUM_W(NUM_W), .DEN_W(DEN_W)
    ) i_sum (
        .str_flat(str_q), .pos_flat(pos_q), .num(num), .den(den)
    );

    assign den_zero = (den == '0);
    assign div_go   = (state_q == ST_LOAD) && !den_zero;

    cog_divider #(.DIVD_W(DIVD_W), .DEN_W(DEN_W)) i_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .dividend(DIVD_W'(num) << FRAC_W), .divisor(den),
        .done(div_done), .quot(quot)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LOAD;
            ST_LOAD:   state_d = den_zero ? ST_FINISH : ST_DIV;
            ST_DIV:    if (div_done) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured operands and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_q    <= '0;
            pos_q    <= '0;
            result_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                str_q <= strength_i;
                pos_q <= position_i;
            end
            if (state_q == ST_LOAD && den_zero) begin
                result_q <= '0;
            end else if (state_q == ST_DIV && div_done) begin
                // Guard: a weighted average never exceeds the top position.
                result_q <= (|quot[DIVD_W-1:OUT_W]) ? '1 : quot[OUT_W-1:0];
            end
        end
    end

    // Outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        valid  = (state_q == ST_FINISH);
        result = result_q;
    end
endmodule

module defuzz_checker #(
    parameter int OUT_W = 10,
    parameter int LIMIT = 768
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             valid,
    input logic [OUT_W-1:0] result
);
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r6_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);
    a_r6_release_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(valid));
    a_r5_accept_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(result) || valid);
    a_r2_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(result) <= LIMIT));
endmodule

bind centroid_defuzz defuzz_checker #(
    .OUT_W(POS_W + FRAC_W),
    .LIMIT(((1 << POS_W) - 1) << FRAC_W)
) i_defuzz_checker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .valid(valid), .result(result)
);

// File: tb/test_centroid_defuzz.sv
module test_centroid_defuzz;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_LAT    = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] strength_i = '0;
    logic [7:0]  position_i = '0;
    logic        busy, valid;
    logic [9:0]  result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string phase = "R1 reset";

    // reference model state
    int  m_cnt = 0;
    int  m_exp = 0;
    int  m_res = 0;
    bit  m_busy = 0;
    bit  m_valid = 0;

    centroid_defuzz i_centroid_defuzz (
        .clk(clk), .rst_n(rst_n), .start(start),
        .strength_i(strength_i), .position_i(position_i),
        .busy(busy), .valid(valid), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int expect_val(logic [31:0] s, logic [7:0] p);
        int n = 0;
        int d = 0;
        for (int k = 0; k < 4; k++) begin
            n += int'(s[8*k +: 8]) * int'(p[2*k +: 2]);
            d += int'(s[8*k +: 8]);
        end
        return (d == 0) ? 0 : (n * 256) / d;
    endfunction

    function automatic bit all_zero(logic [31:0] s);
        return s == 32'd0;
    endfunction

    // Behavioural cycle model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_busy = 0; m_valid = 0; m_res = 0;
        end else if (m_valid) begin
            m_valid = 0;
            m_busy  = 0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_valid = 1;
                m_res   = m_exp;
            end
        end else if (start) begin
            m_busy = 1;
            m_exp  = expect_val(strength_i, position_i);
            m_cnt  = all_zero(strength_i) ? 1 : DIV_LAT;
        end
        cycles++;
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("valid (R3)", int'(valid), int'(m_valid));
            check("busy (R6)", int'(busy), int'(m_busy));
            check("result (R2/R7)", int'(result), m_res);
        end
    end

    task automatic run(logic [31:0] s, logic [7:0] p);
        @(negedge clk);
        strength_i = s;
        position_i = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        int seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        phase = "R1 reset";
        check("valid", int'(valid), 0);
        check("busy", int'(busy), 0);
        check("result", int'(result), 0);
        rst_n = 1'b1;

        phase = "R8 single rule pos 2";
        run(32'h0000_5A00, 8'b00_00_10_00);
        phase = "R8 full scale";
        run(32'hFFFF_FFFF, 8'hFF);
        phase = "R4 zero denominator";
        run(32'h0, 8'hFF);
        phase = "R2 mixed";
        run(32'h10_40_C0_03, 8'b11_01_10_00);
        phase = "R2 mixed lane order";
        run(32'h01_00_00_FE, 8'b11_00_00_01);

        phase = "R5 busy start and late input change";
        @(negedge clk);
        strength_i = 32'h20_30_40_50; position_i = 8'b01_10_11_00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        strength_i = 32'hFF_00_00_00; position_i = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        strength_i = 32'h0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        phase = "R7 hold after zero start";
        run(32'h0, 8'h00);

        phase = "R2 pseudo-random";
        for (int i = 0; i < 40; i++) begin
            seed = seed * 1103515245 + 12345;
            run(32'(seed), 8'(seed >>> 13));
        end
        repeat (5) @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        fails++;
        $display("FAIL watchdog: run hung");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule